// File: doc/BRIEF.md
# Regulator Fault Supervisor

This block watches the digitized operating conditions of a buck regulator: the output voltage, the input voltage, the output current and the die temperature. It also watches the current-limit flags that the power stages return, one per phase. Each sample is compared against programmable warning and fault limits. The result is held in a set of sticky status bits. An alert line is raised for faults, and a shutdown command goes to the PWM stage.

Two fault paths need more than one event before they act. An output over-voltage fault needs a second over-limit reading within a short window after the first. A single reading counts only as a transient. A current-limit fault needs the number of flag rising edges, summed over all phases, to go above a programmable count. Each fault class has a 2-bit response code. The code makes the block record the fault only, latch the stage off until software clears it, or run a hiccup cycle. In a hiccup cycle the stage is held off for a programmable interval and then a restart is requested.

The input-voltage gate uses two thresholds, so conversion is allowed above one level and withdrawn only below a lower one. A clear command returns all fault state to idle.

Top module: `reg_fault_guard`

## Requirements
- R1: On a cycle with `sample_valid` high, status bits are set as follows, with over-limits strict (`>`) and under-limits strict (`<`), and warning and fault limits independent of each other:
  - bit 1 when `vout_smp > ov_warn_lim`
  - bit 3 when `vout_smp < uv_warn_lim`
  - bit 2 when `vout_smp < uv_fault_lim`
  - bit 5 when `iout_smp > oc_warn_lim`
  - bit 7 when `temp_smp > ot_warn_lim`
  - bit 6 when `temp_smp > ot_fault_lim`

  Each bit is visible after the clock edge that takes the sample.
- R2: Output over-voltage fault (status bit 0) is set only when a second reading above `ov_fault_lim` arrives at most `OV_WIN` cycles after a first one. A later second reading is treated as a new first reading.
- R3: Rising edges of `ilim_flag` are counted over all phases, and edges in the same cycle each count. Current-limit fault (status bit 4) is set once the count exceeds `ilim_count_lim`, and never while it is equal to or below it.
- R4: The edge count returns to zero when `sw_period` consecutive cycles pass without any flag edge.
- R5: Each fault class has its own response code: `rsp_ov` for bit 0, `rsp_uv` for bit 2, `rsp_oc` for bit 4 and `rsp_ot` for bit 6. Code 00 records the fault and leaves `shutdown` low.
- R6: Response code 01 raises `shutdown` and holds it until `clear_faults`. No restart is requested.
- R7: Response codes 10 and 11 (hiccup) raise `shutdown` for `retry_cycles`+1 cycles. Then `shutdown` falls and `restart_req` is high for exactly that one cycle.
- R8: `vin_ok` rises on a sample with `vin_smp > vin_on_lim` and falls only on a sample with `vin_smp < vin_off_lim`. Between the two limits it keeps its value.
- R9: `alert` is high exactly when one of the fault bits 0, 2, 4 or 6 is latched. Warning bits alone never raise it.
- R10: `clear_faults` zeroes the status and `alert`, releases a latched or hiccup shutdown, closes an open over-voltage window and zeroes the edge count.
- R11: Status bits are sticky: once set, a bit stays set until `clear_faults`, even when later samples are in range.
- R12: After reset, `status`, `alert`, `shutdown`, `restart_req` and `vin_ok` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | The four sample inputs are valid this cycle |
| vout_smp | input | W | Output voltage sample |
| vin_smp | input | W | Input voltage sample |
| iout_smp | input | W | Output current sample |
| temp_smp | input | W | Temperature sample |
| ov_warn_lim | input | W | Output over-voltage warning limit |
| ov_fault_lim | input | W | Output over-voltage fault limit |
| uv_warn_lim | input | W | Output under-voltage warning limit |
| uv_fault_lim | input | W | Output under-voltage fault limit |
| oc_warn_lim | input | W | Output current warning limit |
| ot_warn_lim | input | W | Temperature warning limit |
| ot_fault_lim | input | W | Temperature fault limit |
| vin_on_lim | input | W | Input level that enables conversion |
| vin_off_lim | input | W | Input level that disables conversion |
| ilim_flag | input | PHASES | Current-limit flags, one per phase |
| ilim_count_lim | input | CNTW | Flag edge count that must be exceeded |
| sw_period | input | PW | Idle cycles that reset the edge count |
| rsp_ov | input | 2 | Response code, output over-voltage |
| rsp_uv | input | 2 | Response code, output under-voltage |
| rsp_oc | input | 2 | Response code, current limit |
| rsp_ot | input | 2 | Response code, over-temperature |
| retry_cycles | input | RW | Hiccup off interval minus one |
| clear_faults | input | 1 | Clear all latched fault state |
| status | output | 8 | Sticky status bits |
| alert | output | 1 | A fault bit is latched |
| shutdown | output | 1 | Turn the PWM outputs off |
| restart_req | output | 1 | One-cycle restart request after a hiccup |
| vin_ok | output | 1 | Input voltage permits conversion |

## Verification
The bench builds the block with W=8, OV_WIN=8, PW=6 and RW=4. With 8-bit samples, every limit comparison can be swept across the whole input range in steps, with both boundaries hit. With an 8-cycle window, the over-voltage filter is exercised at every gap from 2 to 12 cycles, which covers the last accepted and first rejected spacing. The small period and retry widths keep the idle-reset and hiccup timing short, so they can be counted cycle by cycle. Flag counts are swept over several limits, including a limit of zero and simultaneous edges on both phases.

// File: rtl/rfg_pkg.sv
package rfg_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_WAIT} rfg_state_e;

  localparam int unsigned SB_OVF = 0;
  localparam int unsigned SB_OVW = 1;
  localparam int unsigned SB_UVF = 2;
  localparam int unsigned SB_UVW = 3;
  localparam int unsigned SB_OCF = 4;
  localparam int unsigned SB_OCW = 5;
  localparam int unsigned SB_OTF = 6;
  localparam int unsigned SB_OTW = 7;
  localparam int unsigned NSTAT  = 8;
  localparam int unsigned NCLASS = 4;

  localparam logic [NSTAT-1:0] FAULT_MASK = 8'b0101_0101;
  localparam logic [1:0] RSP_LATCH = 2'b01;
endpackage

// File: rtl/rfg_ov_filter.sv
module rfg_ov_filter #(
  parameter int W   = 12,
  parameter int WIN = 20000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         valid,
  input  logic [W-1:0] sample,
  input  logic [W-1:0] limit,
  output logic         fire
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] win_cnt;
  logic          over;

  assign over = valid && (sample > limit);
  assign fire = over && (win_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_cnt <= '0;
    end else if (over) begin
      win_cnt <= fire ? '0 : CW'(WIN);
    end else if (win_cnt != '0) begin
      win_cnt <= win_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rfg_flag_counter.sv
module rfg_flag_counter #(
  parameter int PHASES = 2,
  parameter int CNTW   = 16,
  parameter int PW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [PHASES-1:0] flags,
  input  logic [CNTW-1:0]   limit,
  input  logic [PW-1:0]     period,
  output logic              trip
);
  localparam int NW  = $clog2(PHASES + 1);
  localparam int CCW = CNTW + 1;

  logic [PHASES-1:0] flags_q;
  logic [PHASES-1:0] rises;
  logic [NW-1:0]     n_rise;
  logic [CCW-1:0]    count, count_n, limit_x;
  logic [PW-1:0]     idle;
  logic              idle_wrap;

  assign rises   = flags & ~flags_q;
  assign limit_x = CCW'(limit);

  always_comb begin
    n_rise = '0;
    for (int i = 0; i < PHASES; i++) n_rise = n_rise + NW'(rises[i]);
  end

  assign count_n   = count[CNTW] ? count : count + CCW'(n_rise);
  assign idle_wrap = ((PW+1)'(idle) + (PW+1)'(1)) >= (PW+1)'(period);

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
      idle  <= '0;
      trip  <= 1'b0;
    end else if (n_rise != '0) begin
      count <= count_n;
      idle  <= '0;
      trip  <= count_n > limit_x;
    end else if (idle_wrap) begin
      count <= '0;
      idle  <= '0;
      trip  <= 1'b0;
    end else begin
      idle  <= idle + 1'b1;
      trip  <= count > limit_x;
    end
  end
endmodule

// File: rtl/rfg_vin_hyst.sv
module rfg_vin_hyst #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] vin,
  input  logic [W-1:0] on_lim,
  input  logic [W-1:0] off_lim,
  output logic         ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ok <= 1'b0;
    end else if (valid) begin
      if (!ok && (vin > on_lim))       ok <= 1'b1;
      else if (ok && (vin < off_lim))  ok <= 1'b0;
    end
  end
endmodule

// File: rtl/reg_fault_guard.sv
module reg_fault_guard
  import rfg_pkg::*;
#(
  parameter int W      = 12,
  parameter int OV_WIN = 20000,
  parameter int PHASES = 2,
  parameter int CNTW   = 16,
  parameter int PW     = 10,
  parameter int RW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_valid,
  input  logic [W-1:0]      vout_smp,
  input  logic [W-1:0]      vin_smp,
  input  logic [W-1:0]      iout_smp,
  input  logic [W-1:0]      temp_smp,
  input  logic [W-1:0]      ov_warn_lim,
  input  logic [W-1:0]      ov_fault_lim,
  input  logic [W-1:0]      uv_warn_lim,
  input  logic [W-1:0]      uv_fault_lim,
  input  logic [W-1:0]      oc_warn_lim,
  input  logic [W-1:0]      ot_warn_lim,
  input  logic [W-1:0]      ot_fault_lim,
  input  logic [W-1:0]      vin_on_lim,
  input  logic [W-1:0]      vin_off_lim,
  input  logic [PHASES-1:0] ilim_flag,
  input  logic [CNTW-1:0]   ilim_count_lim,
  input  logic [PW-1:0]     sw_period,
  input  logic [1:0]        rsp_ov,
  input  logic [1:0]        rsp_uv,
  input  logic [1:0]        rsp_oc,
  input  logic [1:0]        rsp_ot,
  input  logic [RW-1:0]     retry_cycles,
  input  logic              clear_faults,
  output logic [7:0]        status,
  output logic              alert,
  output logic              shutdown,
  output logic              restart_req,
  output logic              vin_ok
);
  rfg_state_e        state;
  logic [RW-1:0]     rcnt;
  logic [NSTAT-1:0]  set_v;
  logic [NCLASS-1:0] ev;
  logic [1:0]        rsp [NCLASS];
  logic              ov_fire, oc_trip, latch_evt, hic_evt, cnt_clr;

  assign cnt_clr = clear_faults || (state != ST_RUN);

  rfg_ov_filter #(.W(W), .WIN(OV_WIN)) u_ovf (
    .clk(clk), .rst(rst), .clr(clear_faults), .valid(sample_valid),
    .sample(vout_smp), .limit(ov_fault_lim), .fire(ov_fire)
  );

  rfg_flag_counter #(.PHASES(PHASES), .CNTW(CNTW), .PW(PW)) u_flg (
    .clk(clk), .rst(rst), .clr(cnt_clr), .flags(ilim_flag),
    .limit(ilim_count_lim), .period(sw_period), .trip(oc_trip)
  );

  rfg_vin_hyst #(.W(W)) u_vin (
    .clk(clk), .rst(rst), .valid(sample_valid), .vin(vin_smp),
    .on_lim(vin_on_lim), .off_lim(vin_off_lim), .ok(vin_ok)
  );

  always_comb begin
    set_v         = '0;
    set_v[SB_OVF] = ov_fire;
    set_v[SB_OVW] = sample_valid && (vout_smp > ov_warn_lim);
    set_v[SB_UVF] = sample_valid && (vout_smp < uv_fault_lim);
    set_v[SB_UVW] = sample_valid && (vout_smp < uv_warn_lim);
    set_v[SB_OCF] = oc_trip;
    set_v[SB_OCW] = sample_valid && (iout_smp > oc_warn_lim);
    set_v[SB_OTF] = sample_valid && (temp_smp > ot_fault_lim);
    set_v[SB_OTW] = sample_valid && (temp_smp > ot_warn_lim);
  end

  assign ev     = {set_v[SB_OTF], set_v[SB_OCF], set_v[SB_UVF], set_v[SB_OVF]};
  assign rsp[0] = rsp_ov;
  assign rsp[1] = rsp_uv;
  assign rsp[2] = rsp_oc;
  assign rsp[3] = rsp_ot;

  always_comb begin
    latch_evt = 1'b0;
    hic_evt   = 1'b0;
    for (int c = 0; c < NCLASS; c++) begin
      latch_evt = latch_evt | (ev[c] && (rsp[c] == RSP_LATCH));
      hic_evt   = hic_evt   | (ev[c] && rsp[c][1]);
    end
  end

  assign shutdown = (state != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_RUN;
      rcnt        <= '0;
      restart_req <= 1'b0;
      status      <= '0;
      alert       <= 1'b0;
    end else begin
      restart_req <= 1'b0;
      if (clear_faults) begin
        status <= '0;
        alert  <= 1'b0;
        state  <= ST_RUN;
      end else begin
        status <= status | set_v;
        alert  <= |((status | set_v) & FAULT_MASK);
        case (state)
          ST_RUN: begin
            if (latch_evt) begin
              state <= ST_HOLD;
            end else if (hic_evt) begin
              state <= ST_WAIT;
              rcnt  <= retry_cycles;
            end
          end
          ST_WAIT: begin
            if (latch_evt) begin
              state <= ST_HOLD;
            end else if (rcnt == '0) begin
              state       <= ST_RUN;
              restart_req <= 1'b1;
            end else begin
              rcnt <= rcnt - 1'b1;
            end
          end
          default: state <= ST_HOLD;
        endcase
      end
    end
  end
endmodule

// File: rtl/rfg_checker.sv
module rfg_checker
  import rfg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       clear_faults,
  input logic [7:0] status,
  input logic       alert,
  input logic       shutdown,
  input logic       restart_req
);
  // R10: a clear empties status and alert on the following cycle
  a_r10_clear_empties: assert property (@(posedge clk) disable iff (rst)
    clear_faults |=> (status == '0) && !alert);

  // R9: no alert without a latched fault bit
  a_r9_alert_needs_fault: assert property (@(posedge clk) disable iff (rst)
    ((status & FAULT_MASK) == '0) |-> !alert);

  // R11: bits never drop without a clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    !clear_faults |=> ((status & $past(status)) == $past(status)));

  // R7: a restart comes as shutdown falls
  a_r7_restart_on_release: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> (!shutdown && $past(shutdown)));

  // R7: restart is a single-cycle pulse
  a_r7_restart_pulse: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> !restart_req);
endmodule

bind reg_fault_guard rfg_checker u_rfg_checker (
  .clk(clk), .rst(rst), .clear_faults(clear_faults), .status(status),
  .alert(alert), .shutdown(shutdown), .restart_req(restart_req)
);

// File: tb/reg_fault_guard_bench.sv
module reg_fault_guard_bench;
  localparam int W = 8, OV_WIN = 8, PHASES = 2, CNTW = 16, PW = 6, RW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              sample_valid = 1'b0;
  logic [W-1:0]      vout_smp = 8'd120, vin_smp = 8'd90, iout_smp = 8'd10, temp_smp = 8'd50;
  logic [W-1:0]      ov_warn_lim = 8'd180, ov_fault_lim = 8'd200;
  logic [W-1:0]      uv_warn_lim = 8'd60, uv_fault_lim = 8'd40, oc_warn_lim = 8'd100;
  logic [W-1:0]      ot_warn_lim = 8'd120, ot_fault_lim = 8'd150;
  logic [W-1:0]      vin_on_lim = 8'd100, vin_off_lim = 8'd80;
  logic [PHASES-1:0] ilim_flag = '0;
  logic [CNTW-1:0]   ilim_count_lim = '0;
  logic [PW-1:0]     sw_period = 6'd20;
  logic [1:0]        rsp_ov = 2'b00, rsp_uv = 2'b00, rsp_oc = 2'b00, rsp_ot = 2'b00;
  logic [RW-1:0]     retry_cycles = 4'd5;
  logic              clear_faults = 1'b0;
  logic [7:0]        status;
  logic              alert, shutdown, restart_req, vin_ok;

  int total = 0;
  int bad   = 0;

  reg_fault_guard #(.W(W), .OV_WIN(OV_WIN), .PHASES(PHASES), .CNTW(CNTW), .PW(PW), .RW(RW))
  u_reg_fault_guard (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .vout_smp(vout_smp),
    .vin_smp(vin_smp), .iout_smp(iout_smp), .temp_smp(temp_smp),
    .ov_warn_lim(ov_warn_lim), .ov_fault_lim(ov_fault_lim),
    .uv_warn_lim(uv_warn_lim), .uv_fault_lim(uv_fault_lim),
    .oc_warn_lim(oc_warn_lim), .ot_warn_lim(ot_warn_lim), .ot_fault_lim(ot_fault_lim),
    .vin_on_lim(vin_on_lim), .vin_off_lim(vin_off_lim), .ilim_flag(ilim_flag),
    .ilim_count_lim(ilim_count_lim), .sw_period(sw_period),
    .rsp_ov(rsp_ov), .rsp_uv(rsp_uv), .rsp_oc(rsp_oc), .rsp_ot(rsp_ot),
    .retry_cycles(retry_cycles), .clear_faults(clear_faults),
    .status(status), .alert(alert), .shutdown(shutdown),
    .restart_req(restart_req), .vin_ok(vin_ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic smp(input int v, input int vi, input int io, input int t);
    @(negedge clk);
    vout_smp = 8'(v); vin_smp = 8'(vi); iout_smp = 8'(io); temp_smp = 8'(t);
    sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    vout_smp = 8'd120; iout_smp = 8'd10; temp_smp = 8'd50;
  endtask

  task automatic clr();
    @(negedge clk);
    clear_faults = 1'b1;
    @(negedge clk);
    clear_faults = 1'b0;
  endtask

  task automatic pulse(input logic [PHASES-1:0] m);
    @(negedge clk);
    ilim_flag = m;
    @(negedge clk);
    ilim_flag = '0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 status", int'(status), 0);
    chk("R12 alert", int'(alert), 0);
    chk("R12 shutdown", int'(shutdown), 0);
    chk("R12 restart", int'(restart_req), 0);
    chk("R12 vin_ok", int'(vin_ok), 0);

    // R1 R9 R5: vout sweep, all responses record-only
    for (int v = 0; v < 256; v += 3) begin
      clr();
      smp(v, 90, 10, 50);
      chk("R1 ov warn", int'(status[1]), int'(v > 180));
      chk("R1 uv fault", int'(status[2]), int'(v < 40));
      chk("R1 uv warn", int'(status[3]), int'(v < 60));
      chk("R2 single reading", int'(status[0]), 0);
      chk("R9 alert vout", int'(alert), int'(v < 40));
      chk("R5 no shutdown", int'(shutdown), 0);
    end
    for (int t = 0; t < 256; t += 5) begin
      clr();
      smp(120, 90, 10, t);
      chk("R1 ot warn", int'(status[7]), int'(t > 120));
      chk("R1 ot fault", int'(status[6]), int'(t > 150));
      chk("R9 alert temp", int'(alert), int'(t > 150));
    end
    for (int i = 0; i < 256; i += 7) begin
      clr();
      smp(120, 90, i, 50);
      chk("R1 oc warn", int'(status[5]), int'(i > 100));
      chk("R9 warn no alert", int'(alert), 0);
    end

    // R11 sticky
    clr();
    smp(30, 90, 10, 50);
    smp(120, 90, 10, 50);
    smp(120, 90, 10, 50);
    chk("R11 uv sticky", int'(status[2]), 1);
    chk("R11 alert held", int'(alert), 1);

    // R2 window: second reading k cycles after the first
    for (int k = 2; k <= 12; k++) begin
      clr();
      smp(210, 90, 10, 50);
      repeat (k - 2) @(negedge clk);
      smp(210, 90, 10, 50);
      chk("R2 ov window", int'(status[0]), int'(k <= OV_WIN));
    end
    // R10: clear closes an open window
    clr();
    smp(210, 90, 10, 50);
    clr();
    smp(210, 90, 10, 50);
    chk("R10 window closed", int'(status[0]), 0);

    // R3 flag count with latch-off response
    rsp_oc = 2'b01;
    for (int lim = 0; lim < 4; lim++) begin
      for (int n = 0; n <= lim + 2; n++) begin
        ilim_count_lim = 16'(lim);
        clr();
        for (int p = 0; p < n; p++) pulse((p % 2 == 0) ? 2'b01 : 2'b10);
        repeat (3) @(negedge clk);
        chk("R3 count trip", int'(status[4]), int'(n > lim));
        chk("R6 oc latch", int'(shutdown), int'(n > lim));
      end
    end
    ilim_count_lim = 16'd1;
    clr();
    pulse(2'b11);
    repeat (3) @(negedge clk);
    chk("R3 simultaneous edges", int'(status[4]), 1);

    // R4 idle reset
    ilim_count_lim = 16'd2;
    clr();
    pulse(2'b01); pulse(2'b10);
    repeat (30) @(negedge clk);
    pulse(2'b01); pulse(2'b10);
    repeat (3) @(negedge clk);
    chk("R4 idle reset", int'(status[4]), 0);
    pulse(2'b01);
    repeat (3) @(negedge clk);
    chk("R4 count resumes", int'(status[4]), 1);
    rsp_oc = 2'b00;

    // R10: clear zeroes the edge count
    clr();
    pulse(2'b01); pulse(2'b10);
    clr();
    pulse(2'b01);
    repeat (3) @(negedge clk);
    chk("R10 count cleared", int'(status[4]), 0);

    // R6 latch-off on temperature
    rsp_ot = 2'b01;
    clr();
    smp(120, 90, 10, 200);
    for (int c = 0; c < 40; c++) begin
      if (!shutdown || restart_req) begin
        chk("R6 latch held", int'(shutdown), 1);
        break;
      end
      @(negedge clk);
    end
    chk("R6 still off", int'(shutdown), 1);
    clr();
    chk("R10 release", int'(shutdown), 0);
    chk("R10 status", int'(status), 0);
    chk("R10 alert", int'(alert), 0);
    rsp_ot = 2'b00;

    // R7 hiccup on under-voltage
    rsp_uv = 2'b10;
    retry_cycles = 4'd5;
    clr();
    smp(10, 90, 10, 50);
    begin
      int n = 0;
      while (shutdown && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk("R7 off cycles", n, 6);
      chk("R7 restart", int'(restart_req), 1);
      @(negedge clk);
      chk("R7 restart one cycle", int'(restart_req), 0);
      chk("R9 alert kept", int'(alert), 1);
    end
    rsp_uv = 2'b11;
    retry_cycles = 4'd2;
    clr();
    smp(10, 90, 10, 50);
    begin
      int n = 0;
      while (shutdown && n < 50) begin
        n++;
        @(negedge clk);
      end
      chk("R7 code 11 cycles", n, 3);
    end
    rsp_uv = 2'b00;

    // R8 hysteresis
    clr();
    begin
      int seq [8] = '{90, 101, 90, 80, 79, 95, 100, 101};
      int ex  [8] = '{1, 1, 1, 1, 0, 0, 0, 1};
      for (int s = 0; s < 8; s++) begin
        smp(120, seq[s], 10, 50);
        chk("R8 vin hysteresis", int'(vin_ok), (s == 0) ? 0 : ex[s]);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule